// File: doc/BRIEF.md
# USB Packet Sync and PID Checker

This block sits behind a full-speed receive front end that has already undone the NRZI line coding and removed stuffed bits. It takes the recovered bit stream one bit per `bit_valid` strobe, together with an end-of-packet strobe. At each end of packet it reports four things:

- whether the leading sync byte was correct;
- which PID group the packet belongs to;
- whether the PID matched any known value;
- how much payload remains once the type-dependent CRC tail is removed.

For token-style packets it also presents the 11 payload bits that come before the 5-bit CRC.

All results are registered at the end-of-packet edge and stay stable until the next packet ends. A one-cycle `pkt_done` strobe marks each update. Bits are handled in the order they arrive on the wire. All bit patterns below are written with the first received bit as the leftmost (most significant) digit.

Top module: `usb_pid_checker`

## Requirements
- R1: After reset, `pkt_done`, `pkt_kind`, `sync_err`, `pid_unknown`, `pid`, `token_field` and `data_bits` are all zero.
- R2: `sync_err` is set when the first 8 received bits are not 00000001. It is clear when they are 00000001 and the packet is at least 16 bits long.
- R3: PIDs 10000111, 10010110, 10100101 and 10110100 give `pkt_kind` = 1 (token). Received bits 9 to 16 appear on `pid` in arrival order, with the first received bit in bit 7.
- R4: PIDs 11000011 and 11010010 give `pkt_kind` = 2 (data).
- R5: PIDs 01001011, 01011010, 01111000 and 01101001 give `pkt_kind` = 3 (handshake).
- R6: Any other PID gives `pkt_kind` = 0 with `pid_unknown` = 1. The raw value still appears on `pid`, and `sync_err` still reflects the sync byte.
- R7: For a token packet, `token_field` holds the 11 bits received just before the last 5 bits, with the earliest in bit 10. Missing bits of a short packet read as zero. `token_field` is zero for all other kinds.
- R8: For a data packet, `data_bits` equals the number of bits after the PID minus 16, saturating at zero. `data_bits` is zero for all other kinds.
- R9: A packet with fewer than 16 bits gives `sync_err` = 1, `pkt_kind` = 0 and `pid_unknown` = 0.
- R10: `pkt_done` is high for exactly the one cycle after the clock edge that samples `eop`. All result outputs change only on that edge and hold their value until the next one.
- R11: A bit strobed in the same cycle as `eop` is dropped. The next packet always starts counting from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A recovered bit is present on `bit_in` |
| bit_in | input | 1 | Recovered (decoded, unstuffed) bit |
| eop | input | 1 | End-of-packet strobe, one cycle |
| pkt_done | output | 1 | One-cycle strobe: results updated |
| pkt_kind | output | 2 | 0 none/unknown, 1 token, 2 data, 3 handshake |
| sync_err | output | 1 | Bad sync byte or truncated packet |
| pid_unknown | output | 1 | PID matched no known value |
| pid | output | 8 | Raw PID in arrival order |
| token_field | output | 11 | Token payload with CRC5 removed |
| data_bits | output | CNT_W (11) | Data payload length with CRC16 removed |

## Verification
A miscounted bit index would push the PID window by one bit. That shows up on the very next `pkt_done` as a wrong `pid`, a wrong group, or a spurious `pid_unknown`. An error in the tail window or the length arithmetic shifts `token_field` or changes `data_bits` in that same report. A counter that fails to clear at `eop` damages the following packet, not the current one. For that reason a clean packet is always sent right after the eop-collision case. Held outputs are re-sampled several idle cycles after each report, which catches any update made outside the end-of-packet edge.

// File: rtl/usb_pid_pkg.sv
`timescale 1ns/1ps
package usb_pid_pkg;

  typedef enum logic [1:0] {
    PK_NONE   = 2'd0,
    PK_TOKEN  = 2'd1,
    PK_DATA   = 2'd2,
    PK_HSHAKE = 2'd3
  } pkt_kind_e;

  localparam logic [7:0] SYNC_WORD = 8'b0000_0001;
  localparam int unsigned HDR_BITS = 16;

  // PID group lookup, patterns in arrival order (first bit = MSB)
  function automatic pkt_kind_e pid_group(input logic [7:0] p);
    case (p)
      8'b1000_0111, 8'b1001_0110,
      8'b1010_0101, 8'b1011_0100: pid_group = PK_TOKEN;
      8'b1100_0011, 8'b1101_0010: pid_group = PK_DATA;
      8'b0100_1011, 8'b0101_1010,
      8'b0111_1000, 8'b0110_1001: pid_group = PK_HSHAKE;
      default:                    pid_group = PK_NONE;
    endcase
  endfunction

  // Bits left once a CRC tail is removed, never below zero
  function automatic int unsigned strip_tail(input int unsigned total,
                                             input int unsigned tail);
    strip_tail = (total > tail) ? total - tail : 0;
  endfunction

endpackage

// File: rtl/usb_pid_collect.sv
`timescale 1ns/1ps
module usb_pid_collect #(
  parameter int CNT_W = 11,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             eop,
  output logic [7:0]       sync_q,
  output logic [7:0]       pid_q,
  output logic [WIN_W-1:0] win_q,
  output logic [CNT_W-1:0] bit_cnt
);
  import usb_pid_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(8);
  localparam logic [CNT_W-1:0] PID_END  = CNT_W'(HDR_BITS);

  logic take_bit;
  logic in_sync, in_pid;

  assign take_bit = bit_valid && !eop;
  assign in_sync  = bit_cnt < SYNC_END;
  assign in_pid   = !in_sync && (bit_cnt < PID_END);

  always_ff @(posedge clk) begin
    if (!rst_n || eop) begin
      sync_q  <= '0;
      pid_q   <= '0;
      win_q   <= '0;
      bit_cnt <= '0;
    end else if (take_bit) begin
      if (in_sync)     sync_q <= {sync_q[6:0], bit_in};
      else if (in_pid) pid_q  <= {pid_q[6:0], bit_in};
      else             win_q  <= {win_q[WIN_W-2:0], bit_in};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R11: a bit arriving together with eop must not be counted
  a_r11_eop_drops_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && bit_valid) |=> (bit_cnt == '0));

endmodule

// File: rtl/usb_pid_decode.sv
`timescale 1ns/1ps
module usb_pid_decode #(
  parameter int CNT_W    = 11,
  parameter int TOK_BITS = 11,
  parameter int TOK_CRC  = 5,
  parameter int DATA_CRC = 16
) (
  input  logic [7:0]                  sync_q,
  input  logic [7:0]                  pid_q,
  input  logic [TOK_BITS+TOK_CRC-1:0] win_q,
  input  logic [CNT_W-1:0]            bit_cnt,
  output usb_pid_pkg::pkt_kind_e      kind,
  output logic                        sync_bad,
  output logic                        unknown,
  output logic [TOK_BITS-1:0]         tok_field,
  output logic [CNT_W-1:0]            dlen
);
  import usb_pid_pkg::*;

  localparam int WIN_W = TOK_BITS + TOK_CRC;

  logic        truncated;
  pkt_kind_e   raw_kind;
  int unsigned post_bits;

  always_comb begin
    truncated = int'(bit_cnt) < int'(HDR_BITS);
    post_bits = truncated ? 0 : int'(bit_cnt) - HDR_BITS;
    raw_kind  = pid_group(pid_q);
    kind      = truncated ? PK_NONE : raw_kind;
    sync_bad  = truncated || (sync_q != SYNC_WORD);
    unknown   = !truncated && (raw_kind == PK_NONE);
    tok_field = (kind == PK_TOKEN) ? win_q[WIN_W-1 -: TOK_BITS] : '0;
    dlen      = (kind == PK_DATA) ? CNT_W'(strip_tail(post_bits, DATA_CRC)) : '0;
  end

endmodule

// File: rtl/usb_pid_checker.sv
`timescale 1ns/1ps
module usb_pid_checker #(
  parameter int CNT_W    = 11,
  parameter int TOK_BITS = 11,
  parameter int TOK_CRC  = 5,
  parameter int DATA_CRC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic                eop,
  output logic                pkt_done,
  output logic [1:0]          pkt_kind,
  output logic                sync_err,
  output logic                pid_unknown,
  output logic [7:0]          pid,
  output logic [TOK_BITS-1:0] token_field,
  output logic [CNT_W-1:0]    data_bits
);
  import usb_pid_pkg::*;

  localparam int WIN_W = TOK_BITS + TOK_CRC;

  logic [7:0]          sync_q, pid_q;
  logic [WIN_W-1:0]    win_q;
  logic [CNT_W-1:0]    bit_cnt;
  pkt_kind_e           dec_kind;
  logic                dec_sync_bad, dec_unknown;
  logic [TOK_BITS-1:0] dec_tok;
  logic [CNT_W-1:0]    dec_dlen;

  usb_pid_collect #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .eop(eop), .sync_q(sync_q), .pid_q(pid_q), .win_q(win_q),
    .bit_cnt(bit_cnt)
  );

  usb_pid_decode #(.CNT_W(CNT_W), .TOK_BITS(TOK_BITS), .TOK_CRC(TOK_CRC),
                   .DATA_CRC(DATA_CRC)) u_decode (
    .sync_q(sync_q), .pid_q(pid_q), .win_q(win_q), .bit_cnt(bit_cnt),
    .kind(dec_kind), .sync_bad(dec_sync_bad), .unknown(dec_unknown),
    .tok_field(dec_tok), .dlen(dec_dlen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_done    <= 1'b0;
      pkt_kind    <= 2'd0;
      sync_err    <= 1'b0;
      pid_unknown <= 1'b0;
      pid         <= '0;
      token_field <= '0;
      data_bits   <= '0;
    end else begin
      pkt_done <= eop;
      if (eop) begin
        pkt_kind    <= dec_kind;
        sync_err    <= dec_sync_bad;
        pid_unknown <= dec_unknown;
        pid         <= pid_q;
        token_field <= dec_tok;
        data_bits   <= dec_dlen;
      end
    end
  end

  // R10: results move only on an end-of-packet edge
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eop |=> ($stable(pkt_kind) && $stable(sync_err) && $stable(pid)
              && $stable(token_field) && $stable(data_bits)));
  // R6: an unknown PID never carries a group
  a_r6_unknown_no_group: assert property (@(posedge clk) disable iff (!rst_n)
    pid_unknown |-> (pkt_kind == 2'd0));
  // R9: a groupless packet that is not unknown must be a truncated one
  a_r9_trunc_flags_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_kind == 2'd0 && !pid_unknown) |-> sync_err);
  // R7: token field only for tokens
  a_r7_field_token_only: assert property (@(posedge clk) disable iff (!rst_n)
    (token_field != '0) |-> (pkt_kind == 2'd1));
  // R8: payload length only for data
  a_r8_len_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bits != '0) |-> (pkt_kind == 2'd2));

endmodule

// File: tb/usb_pid_checker_test.sv
`timescale 1ns/1ps
module usb_pid_checker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_in = 1'b0, eop = 1'b0;
  logic pkt_done, sync_err, pid_unknown;
  logic [1:0] pkt_kind;
  logic [7:0] pid;
  logic [10:0] token_field;
  logic [10:0] data_bits;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_pid_checker uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .eop(eop), .pkt_done(pkt_done), .pkt_kind(pkt_kind), .sync_err(sync_err),
    .pid_unknown(pid_unknown), .pid(pid), .token_field(token_field),
    .data_bits(data_bits)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Send n bits of v, first bit = v[n-1]; optionally last bit with eop
  task automatic send(input logic [255:0] v, input int n, input bit last_on_eop);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in = v[i];
      eop = (i == 0) && last_on_eop;
    end
    if (!last_on_eop) begin
      @(negedge clk);
      bit_valid = 1'b0;
      eop = 1'b1;
    end
    @(negedge clk);
    bit_valid = 1'b0;
    eop = 1'b0;
  endtask

  task automatic expect_pkt(input string tag, input int kind, input int se,
                            input int unk, input int p, input bit chk_pid,
                            input int tok, input int dl);
    chk({tag, " R10 done"}, pkt_done, 1);
    chk({tag, " kind"}, pkt_kind, kind);
    chk({tag, " R2 sync_err"}, sync_err, se);
    chk({tag, " R6 unknown"}, pid_unknown, unk);
    if (chk_pid) chk({tag, " R3 pid"}, pid, p);
    chk({tag, " R7 token_field"}, token_field, tok);
    chk({tag, " R8 data_bits"}, data_bits, dl);
    repeat (3) @(negedge clk);
    chk({tag, " R10 done low"}, pkt_done, 0);
    chk({tag, " R10 kind held"}, pkt_kind, kind);
    chk({tag, " R10 field held"}, token_field, tok);
  endtask

  task automatic t_reset();
    chk("R1 done", pkt_done, 0);
    chk("R1 kind", pkt_kind, 0);
    chk("R1 sync_err", sync_err, 0);
    chk("R1 unknown", pid_unknown, 0);
    chk("R1 pid", pid, 0);
    chk("R1 token", token_field, 0);
    chk("R1 data_bits", data_bits, 0);
  endtask

  task automatic t_tokens();
    send(256'({8'h01, 8'h87, 11'h5A3, 5'h1F}), 32, 0);
    expect_pkt("R3 R7 OUT", 1, 0, 0, 8'h87, 1, 11'h5A3, 0);
    send(256'({8'h01, 8'hA5, 11'h7FF, 5'h00}), 32, 0);
    expect_pkt("R3 R7 SOF", 1, 0, 0, 8'hA5, 1, 11'h7FF, 0);
    send(256'({8'h01, 8'h96, 11'h001, 5'h15}), 32, 0);
    expect_pkt("R3 IN", 1, 0, 0, 8'h96, 1, 11'h001, 0);
    send(256'({8'h01, 8'hB4, 11'h2C4, 5'h0A}), 32, 0);
    expect_pkt("R3 SETUP", 1, 0, 0, 8'hB4, 1, 11'h2C4, 0);
    // short token: 8 bits after PID -> only 3 bits reach field low end
    send(256'({8'h01, 8'h87, 8'hE5}), 24, 0);
    expect_pkt("R7 short token", 1, 0, 0, 8'h87, 1, 11'h007, 0);
  endtask

  task automatic t_data();
    send(256'({8'h01, 8'hD2, 24'hABCDEF, 16'h1234}), 56, 0);
    expect_pkt("R4 R8 DATA1", 2, 0, 0, 8'hD2, 1, 0, 24);
    send(256'({8'h01, 8'hC3, 64'h0123456789ABCDEF, 16'hFFFF}), 96, 0);
    expect_pkt("R4 R8 DATA0", 2, 0, 0, 8'hC3, 1, 0, 64);
    send(256'({8'h01, 8'hC3, 10'h155}), 26, 0);
    expect_pkt("R8 short data", 2, 0, 0, 8'hC3, 1, 0, 0);
  endtask

  task automatic t_handshake();
    logic [7:0] hs [4] = '{8'h4B, 8'h5A, 8'h78, 8'h69};
    foreach (hs[k]) begin
      send(256'({8'h01, hs[k]}), 16, 0);
      expect_pkt("R5 handshake", 3, 0, 0, hs[k], 1, 0, 0);
    end
  endtask

  task automatic t_unknown_and_sync();
    send(256'({8'h01, 8'hFF, 16'hBEEF}), 32, 0);
    expect_pkt("R6 unknown FF", 0, 0, 1, 8'hFF, 1, 0, 0);
    send(256'({8'h03, 8'h4B}), 16, 0);
    expect_pkt("R2 bad sync", 3, 1, 0, 8'h4B, 1, 0, 0);
    send(256'({8'h80, 8'h00}), 16, 0);
    expect_pkt("R2 R6 bad sync unknown", 0, 1, 1, 8'h00, 1, 0, 0);
  endtask

  task automatic t_truncated();
    send(256'({8'h01, 4'hC}), 12, 0);
    expect_pkt("R9 truncated", 0, 1, 0, 0, 0, 0, 0);
    // R11: 16th bit collides with eop, packet counts only 15 bits
    send(256'({8'h01, 8'h4B}), 16, 1);
    expect_pkt("R11 eop collision", 0, 1, 0, 0, 0, 0, 0);
    send(256'({8'h01, 8'h4B}), 16, 0);
    expect_pkt("R11 next clean", 3, 0, 0, 8'h4B, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tokens();
    t_data();
    t_handshake();
    t_unknown_and_sync();
    t_truncated();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule